// File: doc/BRIEF.md
# UART Receive Timeout and Interrupt Enable Control

This block sits between a UART's receive FIFO and status logic and the host interrupt line. It holds a 16-bit interrupt-enable register with four live enable bits, one for each interrupt source. It measures how long a non-empty receive FIFO has gone with no new character and no host read. It merges the raw status conditions with their enables into one registered interrupt request.

The idle-time measurement uses the 16x oversampling tick enable. The window is four character times. A character is 12 bits long: start, eight data bits, parity and two stops. Four such characters at 16 ticks per bit give 768 ticks.

A DMA-side control bit can turn the timeout into an interrupt source even when the receive-data enable bit is clear. This lets a DMA engine that ignores timeouts hand the leftover characters to the host. All pins are plain control and status signals. The register port is a single-cycle write strobe with a combinational read-back, so there is no back-pressure anywhere.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset, all enable bits, `cfg_rdata_o`, `timeout_o` and `irq_o` are 0.
- R2: A cycle with `cfg_wr_i` high stores `cfg_wdata_i[3:0]` into the enables, and `cfg_rdata_o[3:0]` returns them. The bit meanings are: bit 0 is receive data available and timeout, bit 1 is transmit holding empty, bit 2 is receive line error, and bit 3 is modem status change. Without a write, the enables hold their value.
- R3: `cfg_rdata_o[15:4]` always reads 0, whatever was written to bits 15:4.
- R4: The idle counter advances only in cycles where `tick16_i` is high. `timeout_o` rises on the clock edge that samples the 768th tick after the measurement began. The FIFO must stay non-empty for the whole window, with no receive or read event.
- R5: While `fifo_level_i` is 0, the counter clears. `timeout_o` is then 0 from the next edge on.
- R6: A pulse on `rx_char_i` or `host_rd_i` clears `timeout_o` and restarts the count from zero. A new full window of 768 ticks is then needed.
- R7: Once set, `timeout_o` stays high until one of three things happens: a receive event, a read event, or the FIFO becoming empty. Further ticks do not clear it.
- R8: `irq_o` is a register. On each edge it takes the OR of every raw source ANDed with its enable bit, plus the timeout term.
- R9: The timeout term is `timeout_o` AND (enable bit 0 OR `to_dma_off_i`).
- R10: A write sampled on edge k does not change `irq_o` at edge k. The new enable gating first shows on `irq_o` at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Enable register write strobe |
| cfg_wdata_i | input | 16 | Enable register write data |
| cfg_rdata_o | output | 16 | Enable register read-back |
| fifo_level_i | input | 5 | Receive FIFO fill level |
| rx_char_i | input | 1 | Pulse: a character entered the FIFO |
| host_rd_i | input | 1 | Pulse: the host read the FIFO |
| tick16_i | input | 1 | 16x oversampling tick enable |
| line_err_i | input | 1 | Raw receive line error condition |
| tx_empty_i | input | 1 | Raw transmit holding empty condition |
| rx_avail_i | input | 1 | Raw receive data available condition |
| modem_chg_i | input | 1 | Raw modem status change condition |
| to_dma_off_i | input | 1 | Forces the timeout into the interrupt sources |
| timeout_o | output | 1 | Character timeout flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench probes the exact tick count at which the timeout fires, with ticks both dense and sparse. A design that is off by one would raise the flag at 767 or 769 ticks, or it would count plain clock cycles. It checks that receive and read pulses restart a full window, and that an emptied FIFO suppresses the flag. A design that only paused the counter would fire early after a restart. It checks the DMA override with enable bit 0 clear, where a design missing the override keeps `irq_o` low. It also checks the one-cycle lag between a register write and the interrupt gating, where a design that bypasses the register would change `irq_o` one edge too soon.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned SRC_N = 4;

  // Field order matches bit positions 3..0 of the enable register.
  typedef struct packed {
    logic modem;
    logic line;
    logic txe;
    logic rxa;
  } uirq_en_t;
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
  import uirq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output uirq_en_t          en_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - SRC_N;

  uirq_en_t en_q;
  logic     unused_hi;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q <= uirq_en_t'(wdata_i[SRC_N-1:0]);
    end
  end

  assign unused_hi = ^wdata_i[DATA_W-1:SRC_N];
  assign en_o      = en_q;
  assign rdata_o   = {{PAD_W{1'b0}}, en_q};
endmodule

// File: rtl/uirq_char_timer.sv
module uirq_char_timer #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned LIMIT = 768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic             rx_char_i,
  input  logic             host_rd_i,
  input  logic             tick_i,
  output logic             timeout_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             restart;
  logic             at_max;

  assign restart = (level_i == '0) || rx_char_i || host_rd_i;
  assign at_max  = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick_i && !at_max) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = at_max;
endmodule

// File: rtl/uirq_merge.sv
module uirq_merge
  import uirq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  uirq_en_t en_i,
  input  uirq_en_t raw_i,
  input  logic     timeout_i,
  input  logic     force_to_i,
  output logic     irq_o
);
  logic [SRC_N-1:0] term;
  logic             to_term;
  logic             irq_d;
  logic             irq_q;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign term[i] = raw_i[i] & en_i[i];
  end

  assign to_term = timeout_i & (en_i.rxa | force_to_i);
  assign irq_d   = (|term) | to_term;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LVL_W      = 5,
  parameter int unsigned CHAR_BITS  = 12,
  parameter int unsigned CHAR_COUNT = 4,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              rx_char_i,
  input  logic              host_rd_i,
  input  logic              tick16_i,
  input  logic              line_err_i,
  input  logic              tx_empty_i,
  input  logic              rx_avail_i,
  input  logic              modem_chg_i,
  input  logic              to_dma_off_i,
  output logic              timeout_o,
  output logic              irq_o
);
  localparam int unsigned WINDOW = CHAR_BITS * CHAR_COUNT * OVERSAMPLE;

  uirq_en_t en;
  uirq_en_t raw;
  logic     tmo;

  assign raw = '{modem: modem_chg_i, line: line_err_i,
                 txe: tx_empty_i, rxa: rx_avail_i};

  uirq_enable_reg #(.DATA_W(DATA_W)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .en_o    (en),
    .rdata_o (cfg_rdata_o)
  );

  uirq_char_timer #(.LVL_W(LVL_W), .LIMIT(WINDOW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (fifo_level_i),
    .rx_char_i (rx_char_i),
    .host_rd_i (host_rd_i),
    .tick_i    (tick16_i),
    .timeout_o (tmo)
  );

  uirq_merge u_mrg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .raw_i      (raw),
    .timeout_i  (tmo),
    .force_to_i (to_dma_off_i),
    .irq_o      (irq_o)
  );

  assign timeout_o = tmo;
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic [LVL_W-1:0]  fifo_level_i,
  input logic              rx_char_i,
  input logic              host_rd_i,
  input logic              tick16_i,
  input logic              line_err_i,
  input logic              tx_empty_i,
  input logic              rx_avail_i,
  input logic              modem_chg_i,
  input logic              to_dma_off_i,
  input logic              timeout_o,
  input logic              irq_o
);
  a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(cfg_rdata_o));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[DATA_W-1:4] == '0);

  a_r4_rise_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick16_i |=> !$rose(timeout_o));

  a_r5_empty_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_level_i == '0) |=> !timeout_o);

  a_r6_event_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_char_i || host_rd_i) |=> !timeout_o);

  a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !rx_char_i && !host_rd_i && fifo_level_i != '0) |=> timeout_o);

  // R8, R9: registered OR of gated sources, seen through the read-back port
  a_r8_irq_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past((line_err_i & cfg_rdata_o[2]) | (tx_empty_i & cfg_rdata_o[1]) |
                            (rx_avail_i & cfg_rdata_o[0]) | (modem_chg_i & cfg_rdata_o[3]) |
                            (timeout_o & (cfg_rdata_o[0] | to_dma_off_i))));
endmodule

bind uirq_ctrl uirq_ctrl_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .fifo_level_i (fifo_level_i),
  .rx_char_i    (rx_char_i),
  .host_rd_i    (host_rd_i),
  .tick16_i     (tick16_i),
  .line_err_i   (line_err_i),
  .tx_empty_i   (tx_empty_i),
  .rx_avail_i   (rx_avail_i),
  .modem_chg_i  (modem_chg_i),
  .to_dma_off_i (to_dma_off_i),
  .timeout_o    (timeout_o),
  .irq_o        (irq_o)
);

// File: tb/uirq_ctrl_bench.sv
module uirq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0]  level = '0;
  logic        rxc = 1'b0, hrd = 1'b0, tick = 1'b0;
  logic        lerr = 1'b0, txe = 1'b0, rxa = 1'b0, mchg = 1'b0, dmaoff = 1'b0;
  logic        tmo, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uirq_ctrl u_uirq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .fifo_level_i(level), .rx_char_i(rxc),
    .host_rd_i(hrd), .tick16_i(tick), .line_err_i(lerr), .tx_empty_i(txe),
    .rx_avail_i(rxa), .modem_chg_i(mchg), .to_dma_off_i(dmaoff),
    .timeout_o(tmo), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(logic [15:0] v);
    wr = 1'b1; wdata = v; step(1); wr = 1'b0; wdata = '0;
  endtask

  task automatic quiet();
    level = '0; tick = 1'b0; rxc = 1'b0; hrd = 1'b0;
    lerr = 1'b0; txe = 1'b0; rxa = 1'b0; mchg = 1'b0; dmaoff = 1'b0;
    wr_en(16'h0000); step(2);
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 0);
    chk("R1 timeout", tmo, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_regs();
    wr_en(16'hFFFF);
    chk("R2 rdata low nibble", rdata[3:0], 4'hF);
    chk("R3 upper zero", rdata[15:4], 0);
    wr_en(16'h5A5);
    chk("R2 pattern", rdata, 16'h0005);
    step(3);
    chk("R2 hold", rdata, 16'h0005);
    wr_en(16'h0000);
    chk("R2 clear", rdata, 0);
  endtask

  task automatic t_dense();
    level = 5'd1; tick = 1'b1;
    step(WIN - 1);
    chk("R4 low at 767", tmo, 0);
    step(1);
    chk("R4 high at 768", tmo, 1);
    step(20);
    chk("R7 held", tmo, 1);
    tick = 1'b0;
    quiet();
  endtask

  task automatic t_sparse();
    level = 5'd3;
    for (int i = 0; i < WIN - 1; i++) begin
      tick = 1'b1; step(1); tick = 1'b0; step(2);
    end
    chk("R4 sparse 767", tmo, 0);
    step(10);
    chk("R4 no tick no count", tmo, 0);
    tick = 1'b1; step(1); tick = 1'b0;
    chk("R4 sparse 768", tmo, 1);
    quiet();
  endtask

  task automatic t_empty();
    level = '0; tick = 1'b1;
    step(WIN + 10);
    chk("R5 empty no timeout", tmo, 0);
    level = 5'd2;
    step(WIN);
    chk("R4 after fill", tmo, 1);
    level = '0; step(1);
    chk("R5 empty clears", tmo, 0);
    quiet();
  endtask

  task automatic t_restart(bit use_rd);
    level = 5'd4; tick = 1'b1;
    step(WIN);
    chk("R6 reached", tmo, 1);
    if (use_rd) hrd = 1'b1; else rxc = 1'b1;
    step(1);
    hrd = 1'b0; rxc = 1'b0;
    chk("R6 cleared", tmo, 0);
    step(WIN - 1);
    chk("R6 new window 767", tmo, 0);
    step(1);
    chk("R6 new window 768", tmo, 1);
    quiet();
  endtask

  task automatic t_sources();
    wr_en(16'h000F);
    lerr = 1'b1; step(1); chk("R8 line err", irq, 1); lerr = 1'b0; step(1);
    chk("R8 idle", irq, 0);
    txe = 1'b1; step(1); chk("R8 tx empty", irq, 1); txe = 1'b0;
    rxa = 1'b1; step(1); chk("R8 rx avail", irq, 1); rxa = 1'b0;
    mchg = 1'b1; step(1); chk("R8 modem", irq, 1); mchg = 1'b0;
    wr_en(16'h000B);
    lerr = 1'b1; step(2); chk("R8 masked line err", irq, 0); lerr = 1'b0;
    wr_en(16'h0004);
    txe = 1'b1; rxa = 1'b1; mchg = 1'b1; step(2);
    chk("R8 others masked", irq, 0);
    quiet();
  endtask

  task automatic t_dma();
    wr_en(16'h000E);
    level = 5'd1; tick = 1'b1;
    step(WIN + 2);
    chk("R9 timeout masked", irq, 0);
    dmaoff = 1'b1; step(1);
    chk("R9 forced", irq, 1);
    dmaoff = 1'b0; wr_en(16'h0001); step(1);
    chk("R9 enable bit0", irq, 1);
    quiet();
  endtask

  task automatic t_wtiming();
    lerr = 1'b1; step(2);
    chk("R10 before", irq, 0);
    wr = 1'b1; wdata = 16'h0004; step(1); wr = 1'b0;
    chk("R10 same edge", irq, 0);
    step(1);
    chk("R10 next edge", irq, 1);
    quiet();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_dense();
    t_sparse();
    t_empty();
    t_restart(1'b0);
    t_restart(1'b1);
    t_sources();
    t_dma();
    t_wtiming();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule